// File: doc/BRIEF.md
# ECC Syndrome Classifier for 256-Byte Chunks

This block takes two 22-bit error-correcting codes for the same 256-byte chunk and decides what went wrong. The first code was read back from storage. The second was recomputed over the data as it arrived. Each code is an 11-bit parity word in the low half and its 11-bit complement-parity word in the high half.

The block XORs the two codes into a syndrome and counts the set bits. It also checks that every parity bit and its partner bit disagree. From these it reports one of four outcomes:

- clean data;
- a fault confined to the stored code bits;
- a single flipped data bit that can be repaired;
- damage that cannot be repaired.

For the repairable case it also gives the byte offset inside the chunk, the bit position inside that byte, and a one-hot mask. The caller XORs the mask into that byte.

The caller presents both codes with a one-cycle start strobe. The result is registered. The done pulse comes on the clock after the strobe. All outputs then hold until the next strobe. Memory access and page sequencing belong to the surrounding controller.

Top module: `ecc_syndrome_classifier`

## Requirements
- R1: While reset is held, and right after it is released, status is 0, fail is 0, done is 0, and the byte index, bit index and mask are all 0.
- R2: When start is sampled high, done is high on the next clock for exactly one cycle. Done is low on every clock that follows a cycle with start low.
- R3: Status is 0 (clean) and fail is 0 in any of these cases: the two codes are equal, the recomputed code is all zeros, or the stored code is all zeros. These checks take precedence over every other rule.
- R4: When none of the R3 cases applies and exactly one bit of the 22-bit syndrome (recomputed XOR stored) is set, status is 1 (code-only fault) and fail is 1.
- R5: When none of the R3 cases applies, the syndrome has exactly 11 bits set, and the check value is 0x7FF, status is 2 (corrected) and fail is 0. The check value is (recomputed low 11 bits XOR recomputed high 11 bits) XOR (stored low 11 bits XOR stored high 11 bits).
- R6: When none of R3, R4 or R5 applies, status is 3 (uncorrectable) and fail is 1.
- R7: When status is 2, the bit index is syndrome bits [2:0], the byte index is syndrome bits [10:3], and the mask is a single 1 at the bit index. For any other status, all three are 0.
- R8: Status, fail, byte index, bit index and mask change only on the clock that follows a start. Otherwise they keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Strobe: classify the codes presented this cycle |
| calc_code | input | 22 | Code recomputed over the data |
| stored_code | input | 22 | Code read back from storage |
| status | output | 2 | 0 clean, 1 code-only fault, 2 corrected, 3 uncorrectable |
| fail | output | 1 | High for status 1 or 3 |
| byte_idx | output | 8 | Offset of the failing byte within the chunk |
| bit_idx | output | 3 | Failing bit within that byte |
| bit_mask | output | 8 | One-hot repair mask for the failing byte |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench builds the block with the default parity width of 11. That gives 22-bit codes and 256-byte chunks.

At this size every one of the 2048 repairable data-bit positions can be swept exhaustively. Each of the 22 single-bit code faults can be injected against a nonzero stored code.

Directed cases cover the zero-code precedence and an 11-bit syndrome whose pairs are not complementary. Random code pairs then exercise the uncorrectable path.

// File: rtl/ecc_syndrome_classifier.sv
module ecc_syndrome_classifier #(
  parameter int PAR_W = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [2*PAR_W-1:0]   calc_code,
  input  logic [2*PAR_W-1:0]   stored_code,
  output logic [1:0]           status,
  output logic                 fail,
  output logic [PAR_W-4:0]     byte_idx,
  output logic [2:0]           bit_idx,
  output logic [7:0]           bit_mask,
  output logic                 done
);
  localparam int CODE_W = 2 * PAR_W;
  localparam int CNT_W  = $clog2(CODE_W + 1);
  localparam logic [1:0] ST_CLEAN = 2'd0;
  localparam logic [1:0] ST_CODE  = 2'd1;
  localparam logic [1:0] ST_FIXED = 2'd2;
  localparam logic [1:0] ST_BAD   = 2'd3;

  logic [CODE_W-1:0] syn;
  logic [PAR_W-1:0]  syn_lo, pair_chk;
  logic [CNT_W-1:0]  ones;
  logic              any_zero, pairs_ok;
  logic [1:0]        st_d;

  assign syn      = calc_code ^ stored_code;
  assign syn_lo   = syn[PAR_W-1:0];
  assign pair_chk = (calc_code[PAR_W-1:0] ^ calc_code[CODE_W-1:PAR_W]) ^
                    (stored_code[PAR_W-1:0] ^ stored_code[CODE_W-1:PAR_W]);
  assign any_zero = (syn == '0) || (calc_code == '0) || (stored_code == '0);
  assign pairs_ok = (ones == CNT_W'(PAR_W)) && (&pair_chk);

  always_comb begin
    ones = '0;
    for (int i = 0; i < CODE_W; i++) ones = ones + CNT_W'(syn[i]);
  end

  always_comb begin
    if (any_zero)                    st_d = ST_CLEAN;
    else if (ones == CNT_W'(1))      st_d = ST_CODE;
    else if (pairs_ok)               st_d = ST_FIXED;
    else                             st_d = ST_BAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status   <= ST_CLEAN;
      fail     <= 1'b0;
      byte_idx <= '0;
      bit_idx  <= '0;
      bit_mask <= '0;
      done     <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        status <= st_d;
        fail   <= (st_d == ST_CODE) || (st_d == ST_BAD);
        if (st_d == ST_FIXED) begin
          byte_idx <= syn_lo[PAR_W-1:3];
          bit_idx  <= syn_lo[2:0];
          bit_mask <= 8'(1) << syn_lo[2:0];
        end else begin
          byte_idx <= '0;
          bit_idx  <= '0;
          bit_mask <= '0;
        end
      end
    end
  end

  p_done_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  p_no_spurious_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  p_zero_code_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start && (calc_code == '0 || stored_code == '0) |=> status == ST_CLEAN && !fail);
  p_single_bit_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start && calc_code != '0 && stored_code != '0 && $countones(calc_code ^ stored_code) == 1
    |=> status == ST_CODE && fail);
  p_fixed_not_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && status == ST_FIXED |-> !fail && $countones(bit_mask) == 1 && bit_mask[bit_idx]);
  p_idx_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    status != ST_FIXED |-> byte_idx == '0 && bit_idx == '0 && bit_mask == '0);
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(status) && $stable(fail) && $stable(byte_idx) && $stable(bit_mask));
endmodule

// File: tb/ecc_syndrome_classifier_tb.sv
module ecc_syndrome_classifier_tb_top;
  localparam int PAR_W = 11;
  localparam int CODE_W = 2 * PAR_W;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CODE_W-1:0] calc_code = '0, stored_code = '0;
  logic [1:0] status;
  logic fail, done;
  logic [PAR_W-4:0] byte_idx;
  logic [2:0] bit_idx;
  logic [7:0] bit_mask;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_syndrome_classifier #(.PAR_W(PAR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .calc_code(calc_code),
    .stored_code(stored_code), .status(status), .fail(fail),
    .byte_idx(byte_idx), .bit_idx(bit_idx), .bit_mask(bit_mask), .done(done));

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model(input int c, input int s, output int st,
                                output int bi, output int bt, output int mk);
    int syn, ones, lo, hi, chk;
    syn = c ^ s; ones = 0;
    for (int i = 0; i < CODE_W; i++) ones += (syn >> i) & 1;
    lo = syn & 'h7ff; hi = (syn >> 11) & 'h7ff;
    chk = ((c & 'h7ff) ^ ((c >> 11) & 'h7ff)) ^ ((s & 'h7ff) ^ ((s >> 11) & 'h7ff));
    if (syn == 0 || c == 0 || s == 0) st = 0;
    else if (ones == 1) st = 1;
    else if (ones == 11 && chk == 'h7ff) st = 2;
    else st = 3;
    if (st == 2) begin bi = lo / 8; bt = lo % 8; mk = 1 << bt; end
    else begin bi = 0; bt = 0; mk = 0; end
  endfunction

  task automatic run(input int c, input int s);
    int st, bi, bt, mk;
    string rq;
    model(c, s, st, bi, bt, mk);
    rq = (st == 0) ? "R3" : (st == 1) ? "R4" : (st == 2) ? "R5" : "R6";
    @(negedge clk);
    calc_code = CODE_W'(c); stored_code = CODE_W'(s); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2", "done pulse", int'(done), 1);
    check(rq, "status", int'(status), st);
    check(rq, "fail", int'(fail), (st == 1 || st == 3) ? 1 : 0);
    check("R7", "byte_idx", int'(byte_idx), bi);
    check("R7", "bit_idx", int'(bit_idx), bt);
    check("R7", "bit_mask", int'(bit_mask), mk);
    calc_code = ~calc_code; stored_code = 22'h15a5a5;
    @(negedge clk);
    check("R2", "done low after pulse", int'(done), 0);
    check("R8", "status held", int'(status), st);
    check("R8", "byte_idx held", int'(byte_idx), bi);
    check("R8", "bit_mask held", int'(bit_mask), mk);
  endtask

  initial begin
    int s, v, syn;
    repeat (3) @(negedge clk);
    check("R1", "status in reset", int'(status), 0);
    check("R1", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "status after reset", int'(status), 0);
    check("R1", "fail after reset", int'(fail), 0);
    check("R1", "mask after reset", int'(bit_mask), 0);
    check("R1", "byte after reset", int'(byte_idx), 0);

    run('h12345, 'h12345);
    run(0, 'h2abcde);
    run('h000040, 0);
    run('h3f0f0f ^ 'h7ff, 'h3f0f0f);
    for (int i = 0; i < CODE_W; i++) run('h2d3c1b ^ (1 << i), 'h2d3c1b);
    s = 'h1b7e93;
    for (int p = 0; p < 2048; p++) begin
      syn = p | ((~p & 'h7ff) << 11);
      if ((s ^ syn) == 0) run(s ^ syn ^ 'h1, s ^ 'h1);
      else run(s ^ syn, s);
    end
    run('h1ff003 ^ 'h0a0a0a, 'h0a0a0a);
    run('h000003 ^ 'h155555, 'h155555);
    for (int k = 0; k < 200; k++) begin
      v = int'($urandom) & 'h3fffff;
      s = int'($urandom) & 'h3fffff;
      run(v, s);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG && !finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule